// File: doc/BRIEF.md
# Clock Output Control Decoder

This block decides how a two-output programmable clock source presents its outputs. Four configuration bits give each of two external control pins its role. The first output's pin can gate that output, steer its source between the full-rate clock and the prescaled clock, or request a power-down of the whole device. The second pin either gates the second output or requests a power-down. The block turns these settings into drive enables for both outputs, a source select for the first output, a device power-down flag and a flag that blocks register programming.

Every change to an output is made without glitches. An enable opens or closes only while that output's clock is low. The source select moves only while both candidate clocks are low. Power-down first closes both outputs and only then raises the power-down flag. After reset, and again after every exit from power-down, both outputs stay closed for a start-up window of `STARTUP_CYC` reference cycles. The control pins are asynchronous and pass through a two-stage synchronizer before they are decoded.

Top module: `clkout_ctl`

## Requirements
- R1: While reset is high, o_oe0, o_oe1, o_sel0_div, o_pwrdn and o_prog_lock are all 0.
- R2: After reset and after every fall of o_pwrdn, o_oe0 and o_oe1 stay 0 for at least STARTUP_CYC (default 8000) reference cycles.
- R3: With i_pdn0=0 and i_en0=1, i_ctrl0=1 closes output 0 and i_ctrl0=0 opens it. o_sel0_div follows i_sel0 (1 = prescaled clock).
- R4: With i_pdn0=0, i_en0=0 and i_sel0=1, output 0 stays open, and i_ctrl0 picks its source: 0 gives the full-rate clock (o_sel0_div=0) and 1 gives the prescaled clock (o_sel0_div=1).
- R5: With i_pdn0=i_en0=i_sel0=0, output 0 is never opened, and i_ctrl0=1 requests device power-down.
- R6: With i_pdn0=1, i_en0 has no effect, output 0 is open whenever the device runs, o_sel0_div follows i_sel0, and i_ctrl0=1 requests power-down.
- R7: With i_pdn1=0, i_ctrl1=1 closes output 1 only. With i_pdn1=1, i_ctrl1=1 requests power-down.
- R8: The device powers down when either pin's request is active and that pin's mode bits permit the request.
- R9: o_oe0 changes only in a cycle where the selected clock of output 0 was low, and o_oe1 changes only in a cycle where i_clk_out1 was low.
- R10: o_sel0_div changes only in a cycle where i_clk_full and i_clk_div were both low.
- R11: o_pwrdn is never 1 while either enable is 1. A power-down request first waits for both enables to close. o_pwrdn falls once the request is withdrawn.
- R12: o_prog_lock is 1 from the acceptance of a power-down request while running, through the whole power-down.
- R13: A change on i_ctrl0 or i_ctrl1 reaches the decoder through two flops, so it acts on the state in the third rising edge after it is applied.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst | input | 1 | Synchronous active-high reset |
| i_en0 | input | 1 | Mode bit: pin 0 acts as output-0 gate |
| i_sel0 | input | 1 | Mode bit: output-0 source, or mux mode |
| i_pdn0 | input | 1 | Mode bit: pin 0 acts as power-down |
| i_pdn1 | input | 1 | Mode bit: pin 1 acts as power-down |
| i_ctrl0 | input | 1 | Asynchronous control pin 0 |
| i_ctrl1 | input | 1 | Asynchronous control pin 1 |
| i_clk_full | input | 1 | Full-rate candidate clock level for output 0 |
| i_clk_div | input | 1 | Prescaled candidate clock level for output 0 |
| i_clk_out1 | input | 1 | Clock level driven on output 1 |
| o_oe0 | output | 1 | Output 0 drive enable |
| o_sel0_div | output | 1 | Output 0 source: 1 prescaled, 0 full-rate |
| o_oe1 | output | 1 | Output 1 drive enable |
| o_pwrdn | output | 1 | Device power-down |
| o_prog_lock | output | 1 | Register programming blocked |

## Verification
A power-down request and a pending output close can land in the same cycle. So can a source change and an enable change on output 0. The bench provokes the first case by holding output 1's clock high while pin 0 requests power-down: output 0 drains, output 1 stays open, and the lock must be up while the power-down flag stays low. It then releases the clock and expects the power-down flag only after output 1 has closed. In the second case, both candidate clocks are held high while the mux pin toggles. The select must not move, and the enable must keep its value. A behavioural model compared on every edge judges the cycles in which both land at once.

// File: rtl/ctl_pkg.sv
package ctl_pkg;

    typedef enum logic [1:0] {
        ST_START = 2'd0,
        ST_RUN   = 2'd1,
        ST_DRAIN = 2'd2,
        ST_OFF   = 2'd3
    } seq_e;

    typedef struct packed {
        logic en0;
        logic sel0;
        logic pdn0;
        logic pdn1;
    } cfg_t;

    typedef struct packed {
        logic pd_req;
        logic want0;
        logic div0;
        logic want1;
    } dec_t;

    // pin roles chosen by mode bits
    function automatic dec_t decode(cfg_t c, logic p0, logic p1);
        dec_t d;
        logic pd0;
        logic pd1;
        pd0 = c.pdn0 ? p0 : (!c.en0 && !c.sel0 && p0);
        pd1 = c.pdn1 && p1;
        d.pd_req = pd0 || pd1;
        if (c.pdn0) begin
            d.want0 = 1'b1;
            d.div0  = c.sel0;
        end else if (c.en0) begin
            d.want0 = !p0;
            d.div0  = c.sel0;
        end else if (c.sel0) begin
            d.want0 = 1'b1;
            d.div0  = p0;
        end else begin
            d.want0 = 1'b0;
            d.div0  = 1'b0;
        end
        d.want1 = c.pdn1 ? 1'b1 : !p1;
        return d;
    endfunction

endpackage

// File: rtl/ctl_sync.sv
module ctl_sync #(
    parameter int WIDTH  = 2,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);
    logic [WIDTH-1:0] pipe [STAGES];

    always_ff @(posedge clk) begin
        if (rst) pipe[0] <= '0;
        else     pipe[0] <= d;
    end

    for (genvar g = 1; g < STAGES; g++) begin : g_stage
        always_ff @(posedge clk) begin
            if (rst) pipe[g] <= '0;
            else     pipe[g] <= pipe[g-1];
        end
    end

    assign q = pipe[STAGES-1];
endmodule

// File: rtl/ctl_seq.sv
module ctl_seq
    import ctl_pkg::*;
#(
    parameter int STARTUP_CYC = 8000
) (
    input  logic clk,
    input  logic rst,
    input  logic pd_req,
    input  logic outs_idle,
    output seq_e state
);
    localparam int CW = $clog2(STARTUP_CYC + 1);
    localparam logic [CW-1:0] LAST = CW'(STARTUP_CYC - 1);

    logic [CW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= ST_START;
            cnt   <= '0;
        end else begin
            case (state)
                ST_START: begin
                    if (pd_req) begin
                        state <= ST_OFF;
                        cnt   <= '0;
                    end else if (cnt == LAST) begin
                        state <= ST_RUN;
                        cnt   <= '0;
                    end else begin
                        cnt <= cnt + 1'b1;
                    end
                end
                ST_RUN:   if (pd_req) state <= ST_DRAIN;
                ST_DRAIN: if (outs_idle) state <= ST_OFF;
                ST_OFF: begin
                    if (!pd_req) begin
                        state <= ST_START;
                        cnt   <= '0;
                    end
                end
                default:  state <= ST_START;
            endcase
        end
    end
endmodule

// File: rtl/ctl_gate.sv
module ctl_gate (
    input  logic clk,
    input  logic rst,
    input  logic allow,
    input  logic lvl,
    output logic oe
);
    // enable moves only during the low phase of its clock
    always_ff @(posedge clk) begin
        if (rst)       oe <= 1'b0;
        else if (!lvl) oe <= allow;
    end
endmodule

// File: rtl/clkout_ctl.sv
module clkout_ctl
    import ctl_pkg::*;
#(
    parameter int STARTUP_CYC = 8000,
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic i_en0,
    input  logic i_sel0,
    input  logic i_pdn0,
    input  logic i_pdn1,
    input  logic i_ctrl0,
    input  logic i_ctrl1,
    input  logic i_clk_full,
    input  logic i_clk_div,
    input  logic i_clk_out1,
    output logic o_oe0,
    output logic o_sel0_div,
    output logic o_oe1,
    output logic o_pwrdn,
    output logic o_prog_lock
);
    localparam int NPIN = 2;

    logic [NPIN-1:0] pin_s;
    cfg_t cfg;
    dec_t dec;
    seq_e state;
    logic sel_q;
    logic lvl0;
    logic [NPIN-1:0] allow;
    logic [NPIN-1:0] lvl;
    logic [NPIN-1:0] oe;

    ctl_sync #(.WIDTH(NPIN), .STAGES(SYNC_STAGES)) u_sync (
        .clk (clk),
        .rst (rst),
        .d   ({i_ctrl1, i_ctrl0}),
        .q   (pin_s)
    );

    assign cfg = '{en0: i_en0, sel0: i_sel0, pdn0: i_pdn0, pdn1: i_pdn1};
    assign dec = decode(cfg, pin_s[0], pin_s[1]);

    ctl_seq #(.STARTUP_CYC(STARTUP_CYC)) u_seq (
        .clk       (clk),
        .rst       (rst),
        .pd_req    (dec.pd_req),
        .outs_idle (oe == '0),
        .state     (state)
    );

    // source switch only when both candidates are low
    always_ff @(posedge clk) begin
        if (rst)                         sel_q <= 1'b0;
        else if (!i_clk_full && !i_clk_div) sel_q <= dec.div0;
    end

    assign lvl0     = sel_q ? i_clk_div : i_clk_full;
    assign lvl      = {i_clk_out1, lvl0};
    assign allow[0] = (state == ST_RUN) && dec.want0;
    assign allow[1] = (state == ST_RUN) && dec.want1;

    for (genvar k = 0; k < NPIN; k++) begin : g_out
        ctl_gate u_gate (
            .clk   (clk),
            .rst   (rst),
            .allow (allow[k]),
            .lvl   (lvl[k]),
            .oe    (oe[k])
        );
    end

    assign o_oe0       = oe[0];
    assign o_oe1       = oe[1];
    assign o_sel0_div  = sel_q;
    assign o_pwrdn     = (state == ST_OFF);
    assign o_prog_lock = (state == ST_OFF) || (state == ST_DRAIN);
endmodule

// File: rtl/clkout_ctl_chk.sv
module clkout_ctl_chk #(
    parameter int STARTUP_CYC = 8000
) (
    input logic clk,
    input logic rst,
    input logic i_clk_full,
    input logic i_clk_div,
    input logic i_clk_out1,
    input logic o_oe0,
    input logic o_sel0_div,
    input logic o_oe1,
    input logic o_pwrdn,
    input logic o_prog_lock
);
    localparam int CW = $clog2(STARTUP_CYC + 1);
    localparam logic [CW-1:0] LIM = CW'(STARTUP_CYC);

    logic [CW-1:0] quiet;

    always_ff @(posedge clk) begin
        if (rst || o_pwrdn)  quiet <= '0;
        else if (quiet != LIM) quiet <= quiet + 1'b1;
    end

    a_r2_startup_quiet: assert property (@(posedge clk) disable iff (rst)
        (quiet != LIM) |-> (!o_oe0 && !o_oe1));

    a_r11_pd_after_drain: assert property (@(posedge clk) disable iff (rst)
        o_pwrdn |-> (!o_oe0 && !o_oe1));

    a_r9_oe0_on_low: assert property (@(posedge clk) disable iff (rst)
        !$stable(o_oe0) |-> !$past(o_sel0_div ? i_clk_div : i_clk_full));

    a_r9_oe1_on_low: assert property (@(posedge clk) disable iff (rst)
        !$stable(o_oe1) |-> !$past(i_clk_out1));

    a_r10_sel_on_low: assert property (@(posedge clk) disable iff (rst)
        !$stable(o_sel0_div) |-> (!$past(i_clk_full) && !$past(i_clk_div)));

    a_r12_lock_covers_pd: assert property (@(posedge clk) disable iff (rst)
        o_pwrdn |-> o_prog_lock);
endmodule

bind clkout_ctl clkout_ctl_chk #(.STARTUP_CYC(STARTUP_CYC)) u_chk (
    .clk         (clk),
    .rst         (rst),
    .i_clk_full  (i_clk_full),
    .i_clk_div   (i_clk_div),
    .i_clk_out1  (i_clk_out1),
    .o_oe0       (o_oe0),
    .o_sel0_div  (o_sel0_div),
    .o_oe1       (o_oe1),
    .o_pwrdn     (o_pwrdn),
    .o_prog_lock (o_prog_lock)
);

// File: tb/clkout_ctl_bench.sv
module clkout_ctl_bench;
    localparam int STARTUP = 8000;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic en0 = 1'b1, sel0 = 1'b1, pdn0 = 1'b0, pdn1 = 1'b0;
    logic ctrl0 = 1'b0, ctrl1 = 1'b0;
    logic cf = 1'b0, cd = 1'b0, c1 = 1'b0;
    logic frz0 = 1'b0, frz1 = 1'b0;
    logic oe0, seld, oe1, pwrdn, lock;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    always #5 clk = ~clk;

    clkout_ctl #(.STARTUP_CYC(STARTUP)) u_clkout_ctl (
        .clk(clk), .rst(rst),
        .i_en0(en0), .i_sel0(sel0), .i_pdn0(pdn0), .i_pdn1(pdn1),
        .i_ctrl0(ctrl0), .i_ctrl1(ctrl1),
        .i_clk_full(cf), .i_clk_div(cd), .i_clk_out1(c1),
        .o_oe0(oe0), .o_sel0_div(seld), .o_oe1(oe1),
        .o_pwrdn(pwrdn), .o_prog_lock(lock)
    );

    // candidate clock levels, slower than the reference
    initial begin
        int tick = 0;
        forever begin
            @(negedge clk);
            tick++;
            cf = frz0 ? 1'b1 : ((tick / 2) % 2 == 1);
            cd = frz0 ? 1'b1 : ((tick / 8) % 2 == 1);
            c1 = frz1 ? 1'b1 : ((tick % 6) >= 3);
        end
    end

    // behavioural reference model
    int  m_phase = 0;   // 0 warmup, 1 live, 2 closing, 3 asleep
    int  m_count = 0;
    bit  m_a0, m_b0, m_a1, m_b1;
    bit  m_oe0, m_oe1, m_sel;

    always @(posedge clk) begin
        bit req, w0, s0, w1, lv0, o0, o1, live;
        if (rst) begin
            m_a0 = 0; m_b0 = 0; m_a1 = 0; m_b1 = 0;
            m_oe0 = 0; m_oe1 = 0; m_sel = 0;
            m_phase = 0; m_count = 0;
        end else begin
            req = 0; w0 = 0; s0 = 0;
            if (pdn0 && m_b0) req = 1;
            if (!pdn0 && !en0 && !sel0 && m_b0) req = 1;
            if (pdn1 && m_b1) req = 1;
            if (pdn0 || en0) begin
                s0 = sel0;
                w0 = pdn0 ? 1 : !m_b0;
            end else if (sel0) begin
                s0 = m_b0; w0 = 1;
            end
            w1 = pdn1 ? 1 : !m_b1;
            o0 = m_oe0; o1 = m_oe1;
            live = (m_phase == 1);
            lv0 = m_sel ? cd : cf;
            if (!lv0) m_oe0 = live && w0;
            if (!c1)  m_oe1 = live && w1;
            if (!cf && !cd) m_sel = s0;
            case (m_phase)
                0: if (req) begin m_phase = 3; m_count = 0; end
                   else if (m_count == STARTUP - 1) begin m_phase = 1; m_count = 0; end
                   else m_count++;
                1: if (req) m_phase = 2;
                2: if (!o0 && !o1) m_phase = 3;
                default: if (!req) begin m_phase = 0; m_count = 0; end
            endcase
            m_b0 = m_a0; m_a0 = ctrl0;
            m_b1 = m_a1; m_a1 = ctrl1;
        end
    end

    task automatic chk(string tag, logic act, logic exp, string what);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s: actual %b expected %b", tag, what, act, exp);
        end
    endtask

    // cycle-by-cycle comparison against the model
    always @(negedge clk) begin
        if (!rst && !done) begin
            chk("R9",  oe0,   m_oe0, "model oe0");
            chk("R7",  oe1,   m_oe1, "model oe1");
            chk("R10", seld,  m_sel, "model sel");
            chk("R11", pwrdn, m_phase == 3, "model pwrdn");
            chk("R12", lock,  m_phase >= 2, "model lock");
        end
    end

    task automatic cyc(int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            done = 1;
            fails++; checks++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin
        cyc(3);
        chk("R1", oe0, 0, "reset oe0");
        chk("R1", oe1, 0, "reset oe1");
        chk("R1", seld, 0, "reset sel");
        chk("R1", pwrdn, 0, "reset pwrdn");
        chk("R1", lock, 0, "reset lock");
        rst = 0;
        cyc(STARTUP - 20);
        chk("R2", oe0, 0, "startup oe0");
        chk("R2", oe1, 0, "startup oe1");
        cyc(60);
        // defaults: gate mode on pin 0, gate on pin 1
        chk("R3", oe0, 1, "default oe0");
        chk("R3", seld, 1, "default sel");
        chk("R7", oe1, 1, "default oe1");
        ctrl0 = 1; cyc(40);
        chk("R3", oe0, 0, "gate closes oe0");
        chk("R3", oe1, 1, "oe1 unaffected");
        chk("R3", pwrdn, 0, "gate no pd");
        // mux mode
        en0 = 0; sel0 = 1; cyc(40);
        chk("R4", oe0, 1, "mux oe0");
        chk("R4", seld, 1, "mux pin1 div");
        ctrl0 = 0; cyc(40);
        chk("R4", seld, 0, "mux pin0 full");
        // hold clocks high: nothing may move
        frz0 = 1; frz1 = 1; cyc(2);
        ctrl0 = 1; ctrl1 = 1; cyc(12);
        chk("R10", seld, 0, "sel held while clocks high");
        chk("R9", oe1, 1, "oe1 held while clock high");
        chk("R9", oe0, 1, "oe0 held while clock high");
        frz0 = 0; frz1 = 0; cyc(40);
        chk("R10", seld, 1, "sel after release");
        chk("R7", oe1, 0, "pin1 gate closes oe1");
        chk("R7", pwrdn, 0, "pin1 gate no pd");
        ctrl1 = 0; ctrl0 = 0;
        // output 0 unused mode
        sel0 = 0; cyc(40);
        chk("R5", oe0, 0, "unused oe0");
        chk("R5", pwrdn, 0, "unused no pd");
        ctrl0 = 1; cyc(40);
        chk("R5", pwrdn, 1, "unused pin0 pd");
        chk("R12", lock, 1, "lock in pd");
        ctrl0 = 0; cyc(10);
        chk("R11", pwrdn, 0, "pd released");
        chk("R12", lock, 0, "lock released");
        chk("R2", oe1, 0, "restart quiet");
        cyc(STARTUP + 40);
        chk("R5", oe0, 0, "unused oe0 stays closed");
        chk("R7", oe1, 1, "oe1 after restart");
        // pin 0 as power-down, en0 ignored
        pdn0 = 1; en0 = 0; sel0 = 0; cyc(40);
        chk("R6", oe0, 1, "pd mode oe0");
        chk("R6", seld, 0, "pd mode sel full");
        en0 = 1; sel0 = 1; cyc(40);
        chk("R6", oe0, 1, "en0 ignored");
        chk("R6", seld, 1, "pd mode sel div");
        // drain ordering with output 1 clock held high
        frz1 = 1; cyc(2);
        ctrl0 = 1; cyc(30);
        chk("R11", oe0, 0, "oe0 drained");
        chk("R11", oe1, 1, "oe1 still waiting");
        chk("R11", pwrdn, 0, "no pd before drain");
        chk("R12", lock, 1, "lock during drain");
        frz1 = 0; cyc(20);
        chk("R11", oe1, 0, "oe1 drained");
        chk("R6", pwrdn, 1, "pin0 pd");
        ctrl0 = 0; cyc(STARTUP + 40);
        // pin 1 as power-down, synchronizer latency
        pdn0 = 0; pdn1 = 1; cyc(5);
        ctrl1 = 1; cyc(2);
        chk("R13", lock, 0, "two flops not yet");
        cyc(1);
        chk("R13", lock, 1, "third edge acts");
        cyc(30);
        chk("R7", pwrdn, 1, "pin1 pd");
        ctrl1 = 0; cyc(STARTUP + 40);
        // both pins as power-down, either one suffices
        pdn0 = 1; ctrl0 = 1; cyc(40);
        chk("R8", pwrdn, 1, "pin0 of or");
        ctrl1 = 1; cyc(4);
        ctrl0 = 0; cyc(20);
        chk("R8", pwrdn, 1, "pin1 of or");
        ctrl1 = 0; cyc(10);
        chk("R8", pwrdn, 0, "or cleared");
        done = 1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule